// File: doc/BRIEF.md
# Flash Bulk Read Controller

This block runs a bulk read from a serial flash into a local word FIFO, and a host then empties that FIFO through a one-word access window. Software programs a flash start address, a byte count, a read instruction (opcode, data lane type, dummy clocks) and an address length. It then writes a start bit. The controller issues one read command toward a byte-stream flash engine. It packs the incoming bytes into FIFO words, least significant byte first, and reports how many words are waiting.

When the FIFO fills up, the controller stops accepting bytes until the host frees a slot. Once every byte has been received and the host has popped every word, a sticky done flag rises. A cancel bit aborts the transfer at any point, empties the FIFO and returns the controller to idle.

The register port is a simple synchronous write strobe with a 3-bit register select. Read data is registered: it shows the selected register as it stood at the previous clock edge.

Top module: `flash_bulk_reader`

## Requirements
- R1: After reset: busy and done read 0, the level reads 0, `src_ready` and `cmd_valid` are 0, and the size register reads 2.
- R2: Register selects are 0 control, 1 start address, 2 byte count, 3 read instruction, 4 size and 5 level. Writing 1 to control bit 0 while idle with a nonzero count pulses `cmd_valid` for exactly one cycle after the write edge. During that pulse the command carries the programmed fields: opcode from instruction bits 7:0, lane type from bits 17:16 (0 single, 1 dual, 2 quad), dummy clocks from bits 28:24, and address bytes equal to size bits 3:0 plus 1. Control bit 2 then reads 1 (busy).
- R3: Bytes are packed little-endian, so the first byte lands in bits 7:0. A final partial word has its unused upper bytes at zero. Each window pop returns the next word in order, on `win_data` the cycle after the pop.
- R4: Bits 15:0 of the level register hold the FIFO fill in words. A pop while the FIFO is empty is ignored and leaves the level at 0.
- R5: While the FIFO holds FIFO_DEPTH words, `src_ready` is low and the level reads FIFO_DEPTH. No byte is lost or duplicated across such a pause.
- R6: Done (control bit 5) is set on the edge after the pop that empties the FIFO of the last word, and not before. Busy clears on that same edge.
- R7: Done is sticky. Writing 1 to control bit 5 clears it, and writing 0 there leaves it set.
- R8: Writing 1 to control bit 1 aborts the transfer. On that edge the FIFO is emptied, `src_ready` drops and busy clears, and done is not set. A write with both bit 0 and bit 1 set does not start a transfer.
- R9: A start written while busy is ignored and issues no command.
- R10: A start with a byte count of 0 issues no command and sets done on the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data of the selected register |
| win_pop | input | 1 | Pop one word through the access window |
| win_data | output | WORD_BYTES*8 | Word returned by the last pop |
| cmd_valid | output | 1 | One-cycle flash read command strobe |
| cmd_opcode | output | 8 | Read opcode |
| cmd_addr | output | 32 | Flash start address |
| cmd_addr_bytes | output | 5 | Address length in bytes |
| cmd_lanes | output | 2 | Data lane type |
| cmd_dummy | output | 5 | Dummy clock count |
| src_valid | input | 1 | Flash byte available |
| src_data | input | 8 | Flash byte |
| src_ready | output | 1 | Controller accepts a byte this cycle |

## Verification
`cmd_valid` and busy change on the start write edge. `reg_rdata` lags its select by one edge, so a status change made at edge N becomes readable after edge N+1, and a popped word sits on `win_data` right after the pop edge. Done is due one edge after the final pop and so reads back two edges after it. The bench drives every input and samples every output at the falling edge. It holds the register select steady across the edges it reasons about, checks each status one edge early (expecting the old value) and again at the due edge. To decide which bytes were accepted, it uses the `src_ready` it saw in the previous half cycle.

// File: rtl/fbr_pkg.sv
package fbr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_STREAM = 2'd1,
    ST_DRAIN  = 2'd2
  } xfer_state_e;

  localparam int SEL_W = 3;
  localparam logic [SEL_W-1:0] SEL_CTRL  = 3'd0;
  localparam logic [SEL_W-1:0] SEL_ADDR  = 3'd1;
  localparam logic [SEL_W-1:0] SEL_COUNT = 3'd2;
  localparam logic [SEL_W-1:0] SEL_INSTR = 3'd3;
  localparam logic [SEL_W-1:0] SEL_SIZE  = 3'd4;
  localparam logic [SEL_W-1:0] SEL_LEVEL = 3'd5;

  localparam int BIT_START  = 0;
  localparam int BIT_CANCEL = 1;
  localparam int BIT_BUSY   = 2;
  localparam int BIT_DONE   = 5;

  localparam int INSTR_LANES_LSB = 16;
  localparam int INSTR_DUMMY_LSB = 24;
  localparam int LEVEL_FIELD_W   = 16;
  localparam logic [3:0] SIZE_RESET = 4'd2;
endpackage

// File: rtl/fbr_word_fifo.sv
module fbr_word_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       flush,
  input  logic                       push,
  input  logic [WIDTH-1:0]           push_data,
  input  logic                       pop,
  output logic [WIDTH-1:0]           pop_data,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr_q, rptr_q;
  logic [CW-1:0]    count_q;
  logic             empty, wr_ok, rd_ok;

  assign full  = (count_q == CW'(DEPTH));
  assign empty = (count_q == '0);
  assign wr_ok = push && !full;
  assign rd_ok = pop && !empty;
  assign count = count_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr_q] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rd_ok) pop_data <= mem[rptr_q];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else begin
      if (wr_ok) wptr_q <= bump(wptr_q);
      if (rd_ok) rptr_q <= bump(rptr_q);
      count_q <= count_q + CW'(wr_ok) - CW'(rd_ok);
    end
  end

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);

  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (rst)
    flush |=> (count_q == '0));
endmodule

// File: rtl/fbr_byte_packer.sv
module fbr_byte_packer #(
  parameter int WORD_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clear,
  input  logic                    take,
  input  logic [7:0]              byte_in,
  input  logic                    last,
  output logic                    push,
  output logic [WORD_BYTES*8-1:0] word_out
);
  localparam int LW = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;

  logic [WORD_BYTES-1:0][7:0] hold_q;
  logic [LW-1:0]              lane_q;

  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
    assign word_out[g*8 +: 8] = (take && lane_q == LW'(g)) ? byte_in : hold_q[g];
  end

  assign push = take && (last || lane_q == LW'(WORD_BYTES - 1));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      hold_q <= '0;
      lane_q <= '0;
    end else if (take) begin
      if (push) begin
        hold_q <= '0;
        lane_q <= '0;
      end else begin
        hold_q[lane_q] <= byte_in;
        lane_q         <= lane_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fbr_ctrl.sv
module fbr_ctrl
  import fbr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32,
  parameter int LVL_W  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [LVL_W-1:0] fifo_count,
  input  logic             fifo_full,
  input  logic             src_valid,
  output logic             src_ready,
  output logic             byte_take,
  output logic             byte_last,
  output logic             flush,
  output logic             cmd_valid,
  output logic [7:0]       cmd_opcode,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [4:0]       cmd_addr_bytes,
  output logic [1:0]       cmd_lanes,
  output logic [4:0]       cmd_dummy
);
  xfer_state_e       state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  count_q, left_q;
  logic [7:0]        opcode_q;
  logic [1:0]        lanes_q;
  logic [4:0]        dummy_q;
  logic [3:0]        size_q;
  logic              done_q, busy;
  logic              ctrl_wr, cancel_req, start_req;
  logic [31:0]       ctrl_word, instr_word, rd_mux;

  assign busy       = (state_q != ST_IDLE);
  assign ctrl_wr    = reg_we && (reg_sel == SEL_CTRL);
  assign cancel_req = ctrl_wr && reg_wdata[BIT_CANCEL];
  assign start_req  = ctrl_wr && reg_wdata[BIT_START] && !reg_wdata[BIT_CANCEL];
  assign flush      = cancel_req;

  assign src_ready  = (state_q == ST_STREAM) && !fifo_full && !cancel_req;
  assign byte_take  = src_valid && src_ready;
  assign byte_last  = (left_q == CNT_W'(1));

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      count_q  <= '0;
      opcode_q <= '0;
      lanes_q  <= '0;
      dummy_q  <= '0;
      size_q   <= SIZE_RESET;
    end else if (reg_we) begin
      case (reg_sel)
        SEL_ADDR:  addr_q  <= reg_wdata[ADDR_W-1:0];
        SEL_COUNT: count_q <= reg_wdata[CNT_W-1:0];
        SEL_INSTR: begin
          opcode_q <= reg_wdata[7:0];
          lanes_q  <= reg_wdata[INSTR_LANES_LSB +: 2];
          dummy_q  <= reg_wdata[INSTR_DUMMY_LSB +: 5];
        end
        SEL_SIZE:  size_q  <= reg_wdata[3:0];
        default: ;
      endcase
    end
  end

  // transfer sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q        <= ST_IDLE;
      left_q         <= '0;
      done_q         <= 1'b0;
      cmd_valid      <= 1'b0;
      cmd_opcode     <= '0;
      cmd_addr       <= '0;
      cmd_addr_bytes <= '0;
      cmd_lanes      <= '0;
      cmd_dummy      <= '0;
    end else begin
      cmd_valid <= 1'b0;
      if (ctrl_wr && reg_wdata[BIT_DONE]) done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_req) begin
            if (count_q == '0) begin
              done_q <= 1'b1;
            end else begin
              state_q        <= ST_STREAM;
              left_q         <= count_q;
              cmd_valid      <= 1'b1;
              cmd_opcode     <= opcode_q;
              cmd_addr       <= addr_q;
              cmd_addr_bytes <= {1'b0, size_q} + 5'd1;
              cmd_lanes      <= lanes_q;
              cmd_dummy      <= dummy_q;
            end
          end
        end
        ST_STREAM: begin
          if (cancel_req) begin
            state_q <= ST_IDLE;
          end else if (byte_take) begin
            left_q <= left_q - 1'b1;
            if (byte_last) state_q <= ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          if (cancel_req) begin
            state_q <= ST_IDLE;
          end else if (fifo_count == '0) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // status readback
  always_comb begin
    ctrl_word           = '0;
    ctrl_word[BIT_BUSY] = busy;
    ctrl_word[BIT_DONE] = done_q;
    instr_word          = '0;
    instr_word[7:0]     = opcode_q;
    instr_word[INSTR_LANES_LSB +: 2] = lanes_q;
    instr_word[INSTR_DUMMY_LSB +: 5] = dummy_q;
    case (reg_sel)
      SEL_CTRL:  rd_mux = ctrl_word;
      SEL_ADDR:  rd_mux = 32'(addr_q);
      SEL_COUNT: rd_mux = 32'(count_q);
      SEL_INSTR: rd_mux = instr_word;
      SEL_SIZE:  rd_mux = {28'd0, size_q};
      SEL_LEVEL: rd_mux = {{(32-LEVEL_FIELD_W){1'b0}}, LEVEL_FIELD_W'(fifo_count)};
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end

  assert_cmd_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);

  assert_done_after_drain_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> (fifo_count == '0));

  assert_cancel_to_idle_R8: assert property (@(posedge clk) disable iff (rst)
    cancel_req |=> (!busy && !src_ready));

  assert_start_ignored_busy_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && start_req) |=> !cmd_valid);
endmodule

// File: rtl/flash_bulk_reader.sv
module flash_bulk_reader
  import fbr_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    reg_we,
  input  logic [2:0]              reg_sel,
  input  logic [31:0]             reg_wdata,
  output logic [31:0]             reg_rdata,
  input  logic                    win_pop,
  output logic [WORD_BYTES*8-1:0] win_data,
  output logic                    cmd_valid,
  output logic [7:0]              cmd_opcode,
  output logic [31:0]             cmd_addr,
  output logic [4:0]              cmd_addr_bytes,
  output logic [1:0]              cmd_lanes,
  output logic [4:0]              cmd_dummy,
  input  logic                    src_valid,
  input  logic [7:0]              src_data,
  output logic                    src_ready
);
  localparam int DATA_W = WORD_BYTES * 8;
  localparam int LVL_W  = $clog2(FIFO_DEPTH + 1);

  logic              byte_take, byte_last, flush, word_push, fifo_full;
  logic [DATA_W-1:0] word_bus;
  logic [LVL_W-1:0]  fifo_count;

  fbr_ctrl #(.ADDR_W(32), .CNT_W(32), .LVL_W(LVL_W)) ctrl_i (
    .clk(clk), .rst(rst),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .fifo_count(fifo_count), .fifo_full(fifo_full),
    .src_valid(src_valid), .src_ready(src_ready),
    .byte_take(byte_take), .byte_last(byte_last), .flush(flush),
    .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode), .cmd_addr(cmd_addr),
    .cmd_addr_bytes(cmd_addr_bytes), .cmd_lanes(cmd_lanes), .cmd_dummy(cmd_dummy)
  );

  fbr_byte_packer #(.WORD_BYTES(WORD_BYTES)) pack_i (
    .clk(clk), .rst(rst), .clear(flush),
    .take(byte_take), .byte_in(src_data), .last(byte_last),
    .push(word_push), .word_out(word_bus)
  );

  fbr_word_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) fifo_i (
    .clk(clk), .rst(rst), .flush(flush),
    .push(word_push), .push_data(word_bus),
    .pop(win_pop), .pop_data(win_data),
    .count(fifo_count), .full(fifo_full)
  );
endmodule

// File: tb/flash_bulk_reader_tb_top.sv
`timescale 1ns/1ps
module flash_bulk_reader_tb_top;
  localparam int DEPTH = 16;

  typedef struct packed {
    logic [31:0] addr;
    logic [15:0] count;
    logic [7:0]  opc;
    logic [1:0]  lanes;
    logic [4:0]  dummy;
    logic [3:0]  size;
    logic [7:0]  hold;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{32'h0000_0100, 16'd8,  8'h03, 2'd0, 5'd0,  4'd2, 8'd0},
    '{32'h0123_4567, 16'd7,  8'h6B, 2'd2, 5'd8,  4'd3, 8'd0},
    '{32'h0000_0080, 16'd1,  8'h3B, 2'd1, 5'd8,  4'd2, 8'd0},
    '{32'h0000_0400, 16'd80, 8'hEB, 2'd2, 5'd24, 4'd3, 8'd80},
    '{32'h00AB_CDE0, 16'd5,  8'h0B, 2'd0, 5'd8,  4'd2, 8'd3}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        win_pop = 1'b0;
  logic [31:0] win_data;
  logic        cmd_valid;
  logic [7:0]  cmd_opcode;
  logic [31:0] cmd_addr;
  logic [4:0]  cmd_addr_bytes;
  logic [1:0]  cmd_lanes;
  logic [4:0]  cmd_dummy;
  logic        src_valid = 1'b0;
  logic [7:0]  src_data = '0;
  logic        src_ready;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  flash_bulk_reader #(.FIFO_DEPTH(DEPTH), .WORD_BYTES(4)) dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .win_pop(win_pop), .win_data(win_data),
    .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode), .cmd_addr(cmd_addr),
    .cmd_addr_bytes(cmd_addr_bytes), .cmd_lanes(cmd_lanes), .cmd_dummy(cmd_dummy),
    .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic reg_write(input logic [2:0] sel, input logic [31:0] data);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
    step();
    reg_we = 1'b0;
  endtask

  function automatic logic [7:0] gen_byte(input logic [31:0] a, input int i);
    logic [31:0] t;
    t = (a + 32'(i)) * 32'd29;
    return t[7:0] ^ 8'hA5;
  endfunction

  task automatic run_vec(input vec_t v, input bit probe_w0);
    logic [31:0] expq[$];
    logic [31:0] acc, cur_exp;
    int lane, sent, cycle, pause_st;
    bit ready_seen, pending, last_issued;
    reg_write(3'd1, v.addr);
    reg_write(3'd2, 32'(v.count));
    reg_write(3'd3, {3'd0, v.dummy, 6'd0, v.lanes, 8'd0, v.opc});
    reg_write(3'd4, {28'd0, v.size});
    reg_write(3'd0, 32'h1);
    check("R2 cmd_valid", 32'(cmd_valid), 32'd1);
    check("R2 cmd_opcode", 32'(cmd_opcode), 32'(v.opc));
    check("R2 cmd_addr", cmd_addr, v.addr);
    check("R2 cmd_addr_bytes", 32'(cmd_addr_bytes), 32'(v.size) + 32'd1);
    check("R2 cmd_lanes", 32'(cmd_lanes), 32'(v.lanes));
    check("R2 cmd_dummy", 32'(cmd_dummy), 32'(v.dummy));
    reg_sel = 3'd5;
    acc = '0; lane = 0; sent = 0; cycle = 0; pause_st = 0;
    pending = 1'b0; last_issued = 1'b0; cur_exp = '0;
    src_valid = 1'b1; src_data = gen_byte(v.addr, 0);
    ready_seen = src_ready;
    while (!last_issued && cycle < 4000) begin
      step();
      cycle++;
      if (pending) begin
        check("R3 window word", win_data, cur_exp);
        pending = 1'b0;
      end
      if (src_valid && ready_seen) begin
        acc[lane*8 +: 8] = gen_byte(v.addr, sent);
        sent++; lane++;
        if (lane == 4 || sent == int'(v.count)) begin
          expq.push_back(acc);
          acc = '0; lane = 0;
        end
      end
      if (pause_st == 1) begin
        check("R5 ready low when full", 32'(src_ready), 32'd0);
        check("R5 level at depth", 32'(reg_rdata[15:0]), 32'(DEPTH));
        pause_st = 2;
      end else if (pause_st == 0 && cycle < int'(v.hold) && sent < int'(v.count) && !src_ready) begin
        pause_st = 1;
      end
      win_pop = 1'b0;
      if (cycle >= int'(v.hold) && expq.size() > 0) begin
        win_pop = 1'b1;
        cur_exp = expq.pop_front();
        pending = 1'b1;
        if (sent == int'(v.count) && expq.size() == 0) begin
          last_issued = 1'b1;
          reg_sel = 3'd0;
        end
      end
      src_valid = (sent < int'(v.count));
      src_data  = gen_byte(v.addr, sent);
      ready_seen = src_ready;
    end
    if (v.hold > 60) check("R5 pause observed", 32'(pause_st), 32'd2);
    step();
    win_pop = 1'b0;
    check("R3 final word", win_data, cur_exp);
    step();
    check("R6 done not early", reg_rdata & 32'h24, 32'h04);
    step();
    check("R6 done after drain", reg_rdata & 32'h24, 32'h20);
    if (probe_w0) begin
      reg_write(3'd0, 32'h0);
      step();
      check("R7 done sticky on write 0", reg_rdata & 32'h20, 32'h20);
    end
    reg_write(3'd0, 32'h20);
    step();
    check("R7 done cleared by W1C", reg_rdata & 32'h20, 32'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 cmd_valid", 32'(cmd_valid), 32'd0);
    check("R1 src_ready", 32'(src_ready), 32'd0);
    step();
    check("R1 ctrl status", reg_rdata, 32'd0);
    reg_sel = 3'd4; step();
    check("R1 size reset", reg_rdata, 32'd2);
    reg_sel = 3'd5; step();
    check("R1 level reset", reg_rdata, 32'd0);

    foreach (VECS[i]) run_vec(VECS[i], i == 0);

    // R10 zero-length start
    reg_write(3'd2, 32'd0);
    reg_write(3'd0, 32'h1);
    check("R10 no command", 32'(cmd_valid), 32'd0);
    step();
    check("R10 done set", reg_rdata & 32'h24, 32'h20);
    reg_write(3'd0, 32'h20);

    // R8 cancel mid-stream
    reg_write(3'd1, 32'h200);
    reg_write(3'd2, 32'd40);
    reg_write(3'd0, 32'h1);
    check("R8 started", 32'(cmd_valid), 32'd1);
    for (int k = 0; k < 10; k++) begin
      src_valid = 1'b1; src_data = 8'(k);
      step();
    end
    src_valid = 1'b0;
    reg_write(3'd0, 32'h2);
    check("R8 ready dropped", 32'(src_ready), 32'd0);
    step();
    check("R8 idle no done", reg_rdata & 32'h24, 32'h00);
    reg_sel = 3'd5; step(); step();
    check("R8 fifo flushed", reg_rdata, 32'd0);
    // R4 pop of empty FIFO
    win_pop = 1'b1; step(); win_pop = 1'b0; step(); step();
    check("R4 empty pop ignored", reg_rdata, 32'd0);
    // R8 start and cancel together
    reg_write(3'd0, 32'h3);
    check("R8 start+cancel no command", 32'(cmd_valid), 32'd0);
    step();
    check("R8 start+cancel stays idle", reg_rdata & 32'h04, 32'h00);

    // R9 start while busy
    reg_write(3'd2, 32'd4);
    reg_write(3'd0, 32'h1);
    check("R9 first start", 32'(cmd_valid), 32'd1);
    reg_write(3'd1, 32'h999);
    reg_write(3'd0, 32'h1);
    check("R9 no second command", 32'(cmd_valid), 32'd0);
    step();
    check("R9 still busy", reg_rdata & 32'h04, 32'h04);
    reg_write(3'd0, 32'h2);
    step();
    check("R9 cleanup idle", reg_rdata & 32'h04, 32'h00);

    finish_sim();
  end
endmodule